// File: doc/BRIEF.md
# Tamper Event Latch and Security Violation Control

This block gathers ten tamper indications and turns them into sticky status bits and a security-violation state. Eight of the indications are asynchronous pulses from external pins or environmental monitors: voltage, clock, temperature, security alarm, external boot, external line A, external line B and wire mesh. Each one is synchronised and edge-detected, so a pulse only one cycle wide is still captured. The other two are single-cycle overflow strobes from a timer counter and a monotonic counter. Both strobes already belong to the block's clock domain.

Each indication always sets its own status bit. A per-source enable decides whether that event also raises the violation flag and the non-valid flag. Software clears the status bits by writing ones to them. The violation flag can only be cleared once no tamper bit is set. Two set-only lock bits, one soft and one hard, block the clearing of tamper bits, so the violation stays in place until the next power-on reset. The violation interrupt is the violation flag gated by an interrupt-enable bit.

Top module: `tamper_guard`

## Requirements
- R1: A pulse on `extTamper[i]`, even one cycle wide, sets status bit 16+i. The eight inputs are ordered voltage, clock, temperature, security alarm, external boot, external A, external B, wire mesh. The bit is visible after the third rising clock edge that follows the pulse, and not after the second.
- R2: A one-cycle `tmrOvf` strobe sets status bit 2, and a one-cycle `monoOvf` strobe sets status bit 3. Each bit is visible right after the clock edge that samples the strobe.
- R3: A write to address 1 loads the enable mask from wrData[9:0]. Bits 0..7 enable `extTamper[0..7]`, bit 8 enables the timer overflow and bit 9 enables the monotonic overflow. An event whose enable bit is set raises the violation flag (status bit 0) on the same edge that latches the event's own status bit.
- R4: An event whose enable bit is clear still sets its status bit but leaves the violation flag unchanged. Writing zero to address 1 disables all ten sources.
- R5: A write to address 0 clears each tamper status bit (2, 3, 16..23) that has a 1 in the same position of wrData. A 0 in wrData leaves the bit unchanged.
- R6: A write to address 0 with wrData[0]=1 clears the violation flag only if no tamper status bit is set in that cycle. Otherwise the flag stays set.
- R7: Every violation also sets the non-valid flag (status bit 1). A write to address 0 with wrData[1]=1 clears the non-valid flag.
- R8: A write to address 2 sets the soft lock if wrData[29]=1 and the hard lock if wrData[30]=1. Both locks are set-only until reset. While either lock is set, writes that would clear tamper status bits have no effect, so the violation flag cannot be cleared either.
- R9: `violIrq` is high exactly when the violation flag is set and the interrupt enable is set. The interrupt enable is loaded from wrData[0] by a write to address 3.
- R10: After reset, every status bit, the enables, both locks, the interrupt enable and `violIrq` are 0.
- R11: If a status bit receives a new event and a write-one-to-clear in the same cycle, the event wins and the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| extTamper | input | 8 | Asynchronous tamper pulses, voltage (0) through wire mesh (7) |
| tmrOvf | input | 1 | Timer-counter overflow strobe, synchronous |
| monoOvf | input | 1 | Monotonic-counter overflow strobe, synchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 status, 1 enables, 2 locks, 3 interrupt enable |
| wrData | input | 32 | Register write data |
| statusWord | output | 32 | Status: bit 0 violation, bit 1 non-valid, bits 2..3 overflows, bits 16..23 external tamper |
| violFlag | output | 1 | Security violation flag |
| nonValid | output | 1 | Non-valid flag |
| violIrq | output | 1 | Violation interrupt |

## Verification
Register writes and overflow strobes take effect one edge after they are sampled. External pulses need three edges: two to pass the synchroniser and one to latch the edge. All inputs are driven on falling edges and held across exactly one rising edge. The table-driven steps then wait four more falling edges before sampling `statusWord`, which is longer than any of these latencies. Separate directed checks sample on the exact falling edges that follow the second and third rising edges after an external pulse, and the first rising edge after an overflow strobe, to pin down the minimum latency.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int NUM_EXT  = 8;
  localparam int NUM_CNT  = 2;
  localparam int NUM_SRC  = NUM_EXT + NUM_CNT;
  localparam int DATA_W   = 32;
  localparam int VIOL_BIT = 0;
  localparam int NV_BIT   = 1;
  localparam int TMR_BIT  = 2;
  localparam int MON_BIT  = 3;
  localparam int EXT_LSB  = 16;
  localparam int SOFT_BIT = 29;
  localparam int HARD_BIT = 30;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_LOCK   = 2'd2,
    SEL_IRQEN  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrDetect;
    logic               clrViol;
    logic               clrNonValid;
    logic               ldEnable;
    logic [NUM_SRC-1:0] enableVal;
    logic               setSoft;
    logic               setHard;
    logic               ldIrq;
    logic               irqVal;
  } tgStrobe_t;
endpackage

// File: rtl/tg_sync_edge.sv
module tg_sync_edge #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] risePulse
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prevLvl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain   <= '0;
        prevLvl <= 1'b0;
      end else begin
        chain   <= {chain[STAGES-2:0], asyncIn[b]};
        prevLvl <= chain[STAGES-1];
      end
    end
    assign risePulse[b] = chain[STAGES-1] & ~prevLvl;
  end
endmodule

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tg_pkg::*;
(
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] detectVec,
  input  logic               lockSoft,
  input  logic               lockHard,
  output tgStrobe_t          strobe
);
  logic               wrStatus;
  logic               lockAny;
  logic [NUM_SRC-1:0] clrMask;
  logic               unusedBits;

  assign wrStatus = wrEn && (regSel_e'(wrAddr) == SEL_STATUS);
  assign lockAny  = lockSoft | lockHard;

  always_comb begin
    for (int i = 0; i < NUM_EXT; i++) clrMask[i] = wrData[EXT_LSB+i];
    clrMask[NUM_EXT]   = wrData[TMR_BIT];
    clrMask[NUM_EXT+1] = wrData[MON_BIT];
  end

  always_comb begin
    strobe             = '0;
    strobe.clrDetect   = (wrStatus && !lockAny) ? clrMask : '0;
    strobe.clrViol     = wrStatus && wrData[VIOL_BIT] && (detectVec == '0);
    strobe.clrNonValid = wrStatus && wrData[NV_BIT];
    strobe.ldEnable    = wrEn && (regSel_e'(wrAddr) == SEL_ENABLE);
    strobe.enableVal   = wrData[NUM_SRC-1:0];
    strobe.setSoft     = wrEn && (regSel_e'(wrAddr) == SEL_LOCK) && wrData[SOFT_BIT];
    strobe.setHard     = wrEn && (regSel_e'(wrAddr) == SEL_LOCK) && wrData[HARD_BIT];
    strobe.ldIrq       = wrEn && (regSel_e'(wrAddr) == SEL_IRQEN);
    strobe.irqVal      = wrData[0];
  end

  assign unusedBits = ^{wrData[DATA_W-1], wrData[28:EXT_LSB+NUM_EXT],
                        wrData[EXT_LSB-1:NUM_SRC]};
endmodule

// File: rtl/tg_datapath.sv
module tg_datapath
  import tg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] eventVec,
  input  tgStrobe_t          strobe,
  output logic [NUM_SRC-1:0] detectVec,
  output logic [NUM_SRC-1:0] enableVec,
  output logic               violFlag,
  output logic               nonValid,
  output logic               lockSoft,
  output logic               lockHard,
  output logic               irqEn
);
  logic enabledHit;
  assign enabledHit = |(eventVec & enableVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detectVec <= '0;
      enableVec <= '0;
      violFlag  <= 1'b0;
      nonValid  <= 1'b0;
      lockSoft  <= 1'b0;
      lockHard  <= 1'b0;
      irqEn     <= 1'b0;
    end else begin
      detectVec <= (detectVec & ~strobe.clrDetect) | eventVec;
      violFlag  <= enabledHit | (violFlag & ~strobe.clrViol);
      nonValid  <= enabledHit | (nonValid & ~strobe.clrNonValid);
      lockSoft  <= lockSoft | strobe.setSoft;
      lockHard  <= lockHard | strobe.setHard;
      if (strobe.ldEnable) enableVec <= strobe.enableVal;
      if (strobe.ldIrq)    irqEn     <= strobe.irqVal;
    end
  end
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EXT-1:0] extTamper,
  input  logic              tmrOvf,
  input  logic              monoOvf,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusWord,
  output logic              violFlag,
  output logic              nonValid,
  output logic              violIrq
);
  logic [NUM_EXT-1:0] extEdge;
  logic [NUM_SRC-1:0] eventVec;
  logic [NUM_SRC-1:0] detectVec;
  logic [NUM_SRC-1:0] enableVec;
  logic               lockSoft;
  logic               lockHard;
  logic               irqEn;
  tgStrobe_t          strobe;

  tg_sync_edge #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(extTamper), .risePulse(extEdge)
  );

  assign eventVec = {monoOvf, tmrOvf, extEdge};

  tg_ctrl u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .detectVec(detectVec),
    .lockSoft(lockSoft), .lockHard(lockHard), .strobe(strobe)
  );

  tg_datapath u_dp (
    .clk(clk), .rstN(rstN), .eventVec(eventVec), .strobe(strobe),
    .detectVec(detectVec), .enableVec(enableVec), .violFlag(violFlag),
    .nonValid(nonValid), .lockSoft(lockSoft), .lockHard(lockHard), .irqEn(irqEn)
  );

  always_comb begin
    statusWord           = '0;
    statusWord[VIOL_BIT] = violFlag;
    statusWord[NV_BIT]   = nonValid;
    statusWord[TMR_BIT]  = detectVec[NUM_EXT];
    statusWord[MON_BIT]  = detectVec[NUM_EXT+1];
    for (int i = 0; i < NUM_EXT; i++) statusWord[EXT_LSB+i] = detectVec[i];
  end

  assign violIrq = violFlag & irqEn;
endmodule

// File: rtl/tg_checker.sv
module tg_checker
  import tg_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] detectVec,
  input logic [NUM_SRC-1:0] enableVec,
  input logic               violFlag,
  input logic               nonValid,
  input logic               lockSoft,
  input logic               lockHard,
  input logic               irqEn,
  input logic               violIrq
);
  AST_NO_ENABLE_NO_VIOL: assert property (@(posedge clk) disable iff (!rstN)
    (enableVec == '0 && !violFlag) |=> !violFlag); // R4
  AST_VIOL_HELD_BY_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    (violFlag && detectVec != '0) |=> violFlag); // R6
  AST_VIOL_SETS_NONVALID: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violFlag) |-> nonValid); // R7
  AST_LOCK_KEEPS_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    (lockSoft || lockHard) |=> ((detectVec & $past(detectVec)) == $past(detectVec))); // R8
  AST_HARD_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockHard |=> lockHard); // R8
  AST_SOFT_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockSoft |=> lockSoft); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    violIrq |-> (violFlag && irqEn)); // R9
endmodule

bind tamper_guard tg_checker u_chk (
  .clk(clk), .rstN(rstN), .detectVec(detectVec), .enableVec(enableVec),
  .violFlag(violFlag), .nonValid(nonValid), .lockSoft(lockSoft),
  .lockHard(lockHard), .irqEn(irqEn), .violIrq(violIrq)
);

// File: tb/tb_tamper_guard.sv
module tb_tamper_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  extTamper = '0;
  logic        tmrOvf = 1'b0;
  logic        monoOvf = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] statusWord;
  logic        violFlag, nonValid, violIrq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tamper_guard dut (
    .clk(clk), .rstN(rstN), .extTamper(extTamper), .tmrOvf(tmrOvf),
    .monoOvf(monoOvf), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusWord(statusWord), .violFlag(violFlag), .nonValid(nonValid),
    .violIrq(violIrq)
  );

  // entry: {write, addr[1:0], data[31:0], stim[9:0] (0..7 ext, 8 tmr, 9 mono), expected status[31:0]}
  localparam int NV = 15;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 2'd0, 32'h0000_0000, 10'h001, 32'h0001_0000}, // R4 disabled source latches only
    {1'b1, 2'd0, 32'h0001_0000, 10'h000, 32'h0000_0000}, // R5
    {1'b1, 2'd1, 32'h0000_03FF, 10'h000, 32'h0000_0000}, // R3 enable all
    {1'b0, 2'd0, 32'h0000_0000, 10'h080, 32'h0080_0003}, // R3 R7 mesh
    {1'b1, 2'd0, 32'h0000_0001, 10'h000, 32'h0080_0003}, // R6 blocked
    {1'b1, 2'd0, 32'h0080_0000, 10'h000, 32'h0000_0003}, // R5
    {1'b1, 2'd0, 32'h0000_0001, 10'h000, 32'h0000_0002}, // R6 allowed
    {1'b1, 2'd0, 32'h0000_0002, 10'h000, 32'h0000_0000}, // R7
    {1'b0, 2'd0, 32'h0000_0000, 10'h100, 32'h0000_0007}, // R2 timer
    {1'b0, 2'd0, 32'h0000_0000, 10'h200, 32'h0000_000F}, // R2 mono
    {1'b1, 2'd0, 32'h0000_000C, 10'h000, 32'h0000_0003}, // R5
    {1'b1, 2'd0, 32'h0000_0003, 10'h000, 32'h0000_0000}, // R6 R7
    {1'b1, 2'd1, 32'h0000_0000, 10'h000, 32'h0000_0000}, // R4 disable all
    {1'b0, 2'd0, 32'h0000_0000, 10'h0FF, 32'h00FF_0000}, // R4 R1
    {1'b1, 2'd0, 32'h00FF_0000, 10'h000, 32'h0000_0000}  // R5
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic drive(input bit wr, input logic [1:0] a, input logic [31:0] d, input logic [9:0] stim);
    @(negedge clk);
    wrEn = wr; wrAddr = a; wrData = d;
    extTamper = stim[7:0]; tmrOvf = stim[8]; monoOvf = stim[9];
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; extTamper = '0; tmrOvf = 1'b0; monoOvf = 1'b0;
  endtask

  task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d, input logic [9:0] stim);
    drive(wr, a, d, stim);
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset status", statusWord, 32'h0);
    check("R10 reset irq", {31'b0, violIrq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][76], VEC[i][75:74], VEC[i][73:42], VEC[i][41:32]);
      check($sformatf("R1-table row %0d", i), statusWord, VEC[i][31:0]);
    end

    // R1 latency: pulse on clock-tamper input
    drive(1'b0, 2'd0, 32'h0, 10'h002);   // rising edge P1 passed
    @(negedge clk);                      // P2 passed
    check("R1 not before third edge", {31'b0, statusWord[17]}, 32'h0);
    @(negedge clk);                      // P3 passed
    check("R1 on third edge", {31'b0, statusWord[17]}, 32'h1);
    step(1'b1, 2'd0, 32'h0002_0000, 10'h0);

    // R2 latency: timer overflow visible after first edge
    drive(1'b0, 2'd0, 32'h0, 10'h100);
    check("R2 one edge", {31'b0, statusWord[2]}, 32'h1);
    step(1'b1, 2'd0, 32'h0000_0004, 10'h0);
    check("R5 cleared timer", statusWord, 32'h0);

    // R9 interrupt gating
    step(1'b1, 2'd1, 32'h0000_03FF, 10'h0);
    step(1'b1, 2'd3, 32'h0000_0001, 10'h0);
    check("R9 no viol no irq", {31'b0, violIrq}, 32'h0);
    step(1'b0, 2'd0, 32'h0, 10'h004);
    check("R9 irq on", {31'b0, violIrq}, 32'h1);
    check("R3 temperature", statusWord, 32'h0004_0003);
    step(1'b1, 2'd3, 32'h0000_0000, 10'h0);
    check("R9 irq masked", {30'b0, violIrq, violFlag}, 32'h1);
    step(1'b1, 2'd0, 32'h0004_0000, 10'h0);
    step(1'b1, 2'd0, 32'h0000_0003, 10'h0);
    check("R6 cleared", statusWord, 32'h0);

    // R11 event beats clear in the same cycle
    step(1'b1, 2'd0, 32'h0000_0004, 10'h100);
    check("R11 set wins", statusWord, 32'h0000_0007);
    step(1'b1, 2'd0, 32'h0000_0004, 10'h0);
    step(1'b1, 2'd0, 32'h0000_0003, 10'h0);
    check("R11 cleanup", statusWord, 32'h0);

    // R8 soft lock
    step(1'b1, 2'd2, 32'h2000_0000, 10'h0);
    step(1'b0, 2'd0, 32'h0, 10'h010);
    check("R8 soft event", statusWord, 32'h0010_0003);
    step(1'b1, 2'd0, 32'h0010_0000, 10'h0);
    check("R8 soft blocks clear", statusWord, 32'h0010_0003);
    step(1'b1, 2'd0, 32'h0000_0001, 10'h0);
    check("R8 soft viol stays", statusWord, 32'h0010_0003);
    step(1'b1, 2'd0, 32'h0000_0002, 10'h0);
    check("R7 nonvalid clear under lock", statusWord, 32'h0010_0001);

    // R10 reset clears locks; R8 hard lock
    doReset();
    check("R10 reset after lock", statusWord, 32'h0);
    step(1'b0, 2'd0, 32'h0, 10'h020);
    check("R10 enables cleared", statusWord, 32'h0020_0000);
    step(1'b1, 2'd0, 32'h0020_0000, 10'h0);
    check("R10 lock cleared", statusWord, 32'h0);
    step(1'b1, 2'd1, 32'h0000_03FF, 10'h0);
    step(1'b1, 2'd2, 32'h4000_0000, 10'h0);
    step(1'b0, 2'd0, 32'h0, 10'h200);
    check("R8 hard event", statusWord, 32'h0000_000B);
    step(1'b1, 2'd0, 32'h0000_0009, 10'h0);
    check("R8 hard blocks clear", statusWord, 32'h0000_000B);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 1 exp 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule